// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block keeps the pending transactions for one direction of a bus bridge and picks which one goes out next. Each entry has a transaction class and an opaque tag. The payload and the bus handshake are handled elsewhere. There are five classes: posted write, delayed read request, delayed write request, delayed read completion and delayed write completion. Memory writes, including write-and-invalidate, are posted writes. Every read is a read request. I/O and configuration writes are write requests.

The destination reports, for each class, whether it can take that class now. An entry is eligible when three conditions hold: it is pending, its class is ready, and the ordering rules let it pass every older pending entry. The block issues the oldest eligible entry. It raises a one-cycle dequeue strobe together with that entry's class and tag, and the entry leaves the queue at the same clock edge. So a blocked head never stalls younger traffic that is allowed to overtake it. A younger entry that must stay behind the head waits.

The queue depth is a parameter. Storage stays in age order: a removed entry closes its gap, and a new entry always goes in behind all surviving entries.

Top module: `ordq_engine`

## Requirements
- R1: After reset the queue is empty, `enq_ready` is 1 and `deq_strobe` is 0.
- R2: A posted write (class code 0) never issues ahead of an older pending posted write.
- R3: A posted write may issue ahead of older read requests (code 1), write requests (code 2), read completions (code 3) and write completions (code 4).
- R4: A read or write request never issues ahead of an older posted write, read request or write request.
- R5: A read or write request may issue ahead of older read and write completions.
- R6: A read or write completion never issues ahead of an older posted write, read completion or write completion.
- R7: A read or write completion may issue ahead of older read and write requests.
- R8: An entry is eligible only if bit `cls` of `dst_ready` is 1 and it may pass every older pending entry. Among the eligible entries the oldest is issued.
- R9: With DEPTH entries held, `enq_ready` is 0 and an enqueue attempt is dropped. No entry is lost or created.
- R10: When an enqueue and a dequeue fall in the same cycle, the count is unchanged. The new entry goes in behind all remaining entries.
- R11: `deq_strobe` is 1 exactly when some entry is eligible. That entry is removed at that clock edge. With no eligible entry the queue is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_cls | input | 3 | Class of the new entry (0..4) |
| enq_tag | input | TAG_W | Tag of the new entry |
| enq_ready | output | 1 | Queue has a free slot |
| dst_ready | input | 5 | Per-class readiness of the destination, bit index = class code |
| deq_strobe | output | 1 | An entry issues this cycle |
| deq_cls | output | 3 | Class of the issued entry |
| deq_tag | output | TAG_W | Tag of the issued entry |

## Verification
Enqueue and dequeue can happen in the same cycle. The bench provokes this by pushing a new posted write on the same edge at which the head issues. It then checks two things: the count stays the same, and the new tag comes out after the older survivors. A second overlap is an enqueue attempt while the queue is full with nothing issuing. A drain of all DEPTH entries must then return the original tags only. The passing rules are judged by loading four entries, opening readiness for a chosen subset of classes, and comparing the first issued tag against the rule table.

// File: rtl/ordq_pkg.sv
package ordq_pkg;

    localparam int NCLS = 5;

    typedef enum logic [2:0] {
        CL_POST  = 3'd0,
        CL_RDREQ = 3'd1,
        CL_WRREQ = 3'd2,
        CL_RDCPL = 3'd3,
        CL_WRCPL = 3'd4
    } ord_cls_e;

    // true when a younger entry of class yng may overtake an older one of class old
    function automatic logic may_pass(input logic [2:0] yng, input logic [2:0] old);
        logic ok;
        case (ord_cls_e'(yng))
            CL_POST:            ok = (old != CL_POST);
            CL_RDREQ, CL_WRREQ: ok = (old == CL_RDCPL) || (old == CL_WRCPL);
            CL_RDCPL, CL_WRCPL: ok = (old == CL_RDREQ) || (old == CL_WRREQ);
            default:            ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/ordq_elig.sv
module ordq_elig
    import ordq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0][2:0] slot_cls,
    input  logic [DEPTH-1:0]      slot_vld,
    input  logic [NCLS-1:0]       cls_rdy,
    output logic [DEPTH-1:0]      elig
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic clear;
        always_comb begin
            clear = 1'b1;
            for (int j = 0; j < i; j++) begin
                if (slot_vld[j] && !may_pass(slot_cls[i], slot_cls[j]))
                    clear = 1'b0;
            end
        end
        assign elig[i] = slot_vld[i] && (slot_cls[i] < 3'(NCLS))
                         && cls_rdy[slot_cls[i]] && clear;
    end

endmodule

// File: rtl/ordq_pick.sv
module ordq_pick #(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end

    // R8: at most one slot issues
    a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8: no requesting slot lies below the granted one (oldest wins)
    a_r8_oldest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((req & (grant - N'(1))) == '0));

endmodule

// File: rtl/ordq_engine.sv
module ordq_engine
    import ordq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [2:0]       enq_cls,
    input  logic [TAG_W-1:0] enq_tag,
    output logic             enq_ready,
    input  logic [4:0]       dst_ready,
    output logic             deq_strobe,
    output logic [2:0]       deq_cls,
    output logic [TAG_W-1:0] deq_tag
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][2:0]       cls;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
        logic [CNT_W-1:0]            count;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0] slot_vld;
    logic [DEPTH-1:0] elig;
    logic [DEPTH-1:0] grant;
    logic [IDX_W-1:0] sel_idx;
    logic             any_elig;
    logic             enq_fire;

    for (genvar i = 0; i < DEPTH; i++) begin : g_vld
        assign slot_vld[i] = (CNT_W'(i) < st_q.count);
    end

    ordq_elig #(.DEPTH(DEPTH)) u_elig (
        .slot_cls (st_q.cls),
        .slot_vld (slot_vld),
        .cls_rdy  (dst_ready),
        .elig     (elig)
    );

    ordq_pick #(.N(DEPTH)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (elig),
        .grant (grant),
        .idx   (sel_idx),
        .any   (any_elig)
    );

    assign enq_ready  = (st_q.count < CNT_W'(DEPTH));
    assign enq_fire   = enq_valid && enq_ready;
    assign deq_strobe = any_elig;
    assign deq_cls    = st_q.cls[sel_idx];
    assign deq_tag    = st_q.tag[sel_idx];

    always_comb begin
        logic [CNT_W-1:0] cnt_mid;
        st_d    = st_q;
        cnt_mid = st_q.count;
        if (any_elig) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= sel_idx) begin
                    st_d.cls[i] = st_q.cls[i+1];
                    st_d.tag[i] = st_q.tag[i+1];
                end
            end
            cnt_mid = st_q.count - CNT_W'(1);
        end
        if (enq_fire) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == cnt_mid) begin
                    st_d.cls[i] = enq_cls;
                    st_d.tag[i] = enq_tag;
                end
            end
        end
        st_d.count = cnt_mid + (enq_fire ? CNT_W'(1) : CNT_W'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    a_r1_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == '0) |-> !deq_strobe);

    a_r10_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_strobe && enq_fire) |=> $stable(st_q.count));

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!deq_strobe && !enq_fire) |=> $stable(st_q.count));

endmodule

// File: tb/sim_ordq_engine.sv
module sim_ordq_engine;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int TAG_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enq_valid = 1'b0;
    logic [2:0]       enq_cls = '0;
    logic [TAG_W-1:0] enq_tag = '0;
    logic             enq_ready;
    logic [4:0]       dst_ready = '0;
    logic             deq_strobe;
    logic [2:0]       deq_cls;
    logic [TAG_W-1:0] deq_tag;

    int checks = 0;
    int failures = 0;

    always #(PERIOD/2) clk = ~clk;

    ordq_engine #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u0 (
        .clk, .rst_n, .enq_valid, .enq_cls, .enq_tag, .enq_ready,
        .dst_ready, .deq_strobe, .deq_cls, .deq_tag
    );

    // classes: 0 posted write, 1 read req, 2 write req, 3 read cpl, 4 write cpl
    localparam int VC [0:7][0:3] = '{
        '{0, 0, 1, 3},   // R2: blocked posted writes hold the rest
        '{1, 2, 3, 0},   // R3: posted write overtakes all
        '{0, 1, 4, 2},   // R4: requests stay behind posted write
        '{3, 4, 1, 0},   // R5: request overtakes completions
        '{4, 3, 1, 3},   // R6: completions stay behind a completion
        '{1, 2, 4, 0},   // R7: completion overtakes requests
        '{3, 1, 2, 0},   // R8: write req blocked by read req, posted write goes
        '{1, 0, 3, 0}    // R8: oldest of several eligible
    };
    localparam logic [4:0] VM [0:7] = '{5'b01010, 5'b00001, 5'b00110, 5'b00010,
                                        5'b01000, 5'b10000, 5'b00101, 5'b01001};
    localparam int VE [0:7] = '{-1, 3, -1, 2, -1, 2, 3, 1};
    localparam int VR [0:7] = '{2, 3, 4, 5, 6, 7, 8, 8};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int cls, input int tag);
        enq_valid = 1'b1;
        enq_cls   = 3'(cls);
        enq_tag   = TAG_W'(tag);
        @(posedge clk);
        #1 enq_valid = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        check(enq_ready === 1'b1, "R1 enq_ready", int'(enq_ready), 1);
        check(deq_strobe === 1'b0, "R1 deq_strobe", int'(deq_strobe), 0);

        // vector table
        for (int v = 0; v < 8; v++) begin
            dst_ready = '0;
            for (int k = 0; k < 4; k++) push(VC[v][k], k + 4 * (v % 4));
            @(negedge clk);
            dst_ready = VM[v];
            #1;
            if (VE[v] < 0) begin
                check(deq_strobe === 1'b0, $sformatf("R%0d none", VR[v]), int'(deq_strobe), 0);
            end else begin
                check(deq_strobe === 1'b1 && int'(deq_tag) == VE[v] + 4 * (v % 4),
                      $sformatf("R%0d first tag", VR[v]), int'(deq_tag), VE[v] + 4 * (v % 4));
            end
            @(posedge clk);
            #1 dst_ready = '0;
            @(negedge clk);
            dst_ready = 5'b11111;
            for (int k = 0; k < 4; k++) begin
                if (k != VE[v]) begin
                    #1;
                    check(deq_strobe === 1'b1 && int'(deq_tag) == k + 4 * (v % 4)
                          && int'(deq_cls) == VC[v][k],
                          $sformatf("R%0d drain", VR[v]), int'(deq_tag), k + 4 * (v % 4));
                    @(negedge clk);
                end
            end
            #1;
            check(deq_strobe === 1'b0, "R11 empty after drain", int'(deq_strobe), 0);
            dst_ready = '0;
        end

        // R11: held entry does not leave while its class is not ready
        push(2, 9);
        @(negedge clk); dst_ready = 5'b11011; #1;
        check(deq_strobe === 1'b0, "R11 blocked", int'(deq_strobe), 0);
        @(negedge clk); dst_ready = 5'b00100; #1;
        check(deq_strobe === 1'b1 && deq_tag == 4'd9, "R11 held entry", int'(deq_tag), 9);
        @(posedge clk); #1 dst_ready = '0;

        // R9: full queue rejects enqueue
        for (int k = 0; k < DEPTH; k++) push(0, k);
        #1;
        check(enq_ready === 1'b0, "R9 full ready", int'(enq_ready), 0);
        push(0, 15);
        @(negedge clk); dst_ready = 5'b00001;
        for (int k = 0; k < DEPTH; k++) begin
            #1;
            check(deq_strobe === 1'b1 && int'(deq_tag) == k, "R9 drain", int'(deq_tag), k);
            @(negedge clk);
        end
        #1;
        check(deq_strobe === 1'b0, "R9 no extra", int'(deq_strobe), 0);
        dst_ready = '0;

        // R10: enqueue and dequeue together
        push(0, 1);
        push(0, 2);
        @(negedge clk);
        dst_ready = 5'b11111;
        enq_valid = 1'b1; enq_cls = 3'd0; enq_tag = 4'd3;
        #1;
        check(deq_strobe === 1'b1 && deq_tag == 4'd1, "R10 head", int'(deq_tag), 1);
        @(posedge clk); #1 enq_valid = 1'b0;
        for (int k = 2; k <= 3; k++) begin
            @(negedge clk); #1;
            check(deq_strobe === 1'b1 && int'(deq_tag) == k, "R10 order", int'(deq_tag), k);
        end
        @(negedge clk); #1;
        check(deq_strobe === 1'b0, "R10 count", int'(deq_strobe), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule